// File: doc/BRIEF.md
# Dual-Strobe Cascadable Up/Down Counter

This block is a reversible binary counter that advances on one input strobe and retreats on another, rather than taking a single clock plus a direction select. Both strobes idle high and are counted on their rising edges. Two active-low terminal-count outputs repeat the low phase of the matching strobe, but only while the count sits at its top or bottom value. Wiring them straight into the strobe inputs of a further instance therefore builds a wider counter with no glue logic.

The block runs on a system clock. Each strobe passes through a synchronizer chain, and its rising edge is found by comparing the synchronized level with the level one cycle earlier. A master clear and an active-low parallel load act in the cycle in which they are sampled. While either of them is active, strobe edges are discarded, but the edge history keeps tracking the strobe levels. A strobe that is held low through a clear or a load is therefore still counted when it rises afterwards.

Top module: `dual_strobe_counter`

## Requirements
- R1: After system reset (rst_n low) the count is 0 and both carry_n and borrow_n are 1.
- R2: A rising edge on inc_strobe, with clr low and load_n high, adds exactly one to the count.
- R3: A rising edge on dec_strobe, with clr low and load_n high, subtracts exactly one from the count.
- R4: The count wraps modulo 2^WIDTH: all-ones plus one gives 0, and 0 minus one gives all-ones.
- R5: carry_n is 0 exactly when the count is all-ones and the synchronized inc_strobe level is 0. It returns to 1 as soon as that level rises.
- R6: borrow_n is 0 exactly when the count is 0 and the synchronized dec_strobe level is 0.
- R7: clr high forces the count to 0 at the next clock edge. It overrides load_n, preset and both strobes.
- R8: With clr low and load_n low, the count takes the value of preset at the next clock edge. Strobe edges that are detected while the load is active are discarded.
- R9: A strobe held low across a clear or a load, and raised after the clear or load ends, is counted once.
- R10: If rising edges on both strobes are detected in the same cycle, the count keeps its value.
- R11: Two instances chained carry_n to inc_strobe and borrow_n to dec_strobe form a counter of 2*WIDTH bits that wraps in both directions.
- R12: A rising edge driven on a strobe changes the count at the (SYNC_STAGES+1)th clock edge that follows it. With SYNC_STAGES=2 that is the third edge, and the count has not changed after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| clr | input | 1 | Master clear, active high |
| load_n | input | 1 | Parallel load, active low |
| preset | input | WIDTH | Value taken on a load |
| inc_strobe | input | 1 | Count-up strobe, idles high, counts on a rising edge |
| dec_strobe | input | 1 | Count-down strobe, idles high, counts on a rising edge |
| count | output | WIDTH | Current count |
| carry_n | output | 1 | Terminal count up, active low |
| borrow_n | output | 1 | Terminal count down, active low |

## Verification
The bench builds two instances with the default WIDTH=4 and SYNC_STAGES=2 and chains them into an 8-bit counter. With four bits per stage, the wrap of the low nibble occurs often, and every carry or borrow into the upper stage has to travel through that stage's synchronizer. The 8-bit wrap in both directions is also reachable within a few strobe pulses once a value is preloaded. The two-stage setting fixes the strobe-to-count latency at three clock edges, which the bench checks exactly.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_INC,
        OP_DEC,
        OP_LOAD,
        OP_CLEAR
    } op_e;

    // Priority: clear, then load, then a single strobe edge; coincident edges cancel
    function automatic op_e pick_op(input logic clr, input logic load_n,
                                    input logic up_edge, input logic dn_edge);
        if (clr)                        return OP_CLEAR;
        else if (!load_n)               return OP_LOAD;
        else if (up_edge && !dn_edge)   return OP_INC;
        else if (dn_edge && !up_edge)   return OP_DEC;
        else                            return OP_HOLD;
    endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_in,
    output logic level,
    output logic rise
);
    localparam int CHAIN_W = (STAGES < 2) ? 2 : STAGES;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
        logic               prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d       = sync_q;
        sync_d.chain = {sync_q.chain[CHAIN_W-2:0], strobe_in};
        sync_d.prev  = sync_q.chain[CHAIN_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q.chain <= '1;
            sync_q.prev  <= 1'b1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign level = sync_q.chain[CHAIN_W-1];
    assign rise  = sync_q.chain[CHAIN_W-1] & ~sync_q.prev;

endmodule

// File: rtl/count_core.sv
module count_core
    import dsc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  op_e              op,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] count
);
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [WIDTH-1:0] count;
    } core_t;

    core_t core_d, core_q;

    always_comb begin
        core_d = core_q;
        unique case (op)
            OP_CLEAR: core_d.count = '0;
            OP_LOAD:  core_d.count = preset;
            OP_INC:   core_d.count = core_q.count + ONE;
            OP_DEC:   core_d.count = core_q.count - ONE;
            default:  core_d.count = core_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign count = core_q.count;

endmodule

// File: rtl/term_detect.sv
module term_detect #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] count,
    input  logic             up_level,
    input  logic             dn_level,
    output logic             carry_n,
    output logic             borrow_n
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    // Echo the low phase of the strobe only at the matching end of the range
    always_comb begin
        carry_n  = ~((count == TOP) & ~up_level);
        borrow_n = ~((count == '0)  & ~dn_level);
    end

endmodule

// File: rtl/dual_strobe_counter.sv
module dual_strobe_counter
    import dsc_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load_n,
    input  logic [WIDTH-1:0] preset,
    input  logic             inc_strobe,
    input  logic             dec_strobe,
    output logic [WIDTH-1:0] count,
    output logic             carry_n,
    output logic             borrow_n
);
    localparam int N_STROBES = 2;

    logic [N_STROBES-1:0] strobe_raw;
    logic [N_STROBES-1:0] strobe_lvl;
    logic [N_STROBES-1:0] strobe_rise;
    op_e                  op;

    assign strobe_raw = {dec_strobe, inc_strobe};

    for (genvar gi = 0; gi < N_STROBES; gi++) begin : g_sync
        strobe_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk       (clk),
            .rst_n     (rst_n),
            .strobe_in (strobe_raw[gi]),
            .level     (strobe_lvl[gi]),
            .rise      (strobe_rise[gi])
        );
    end

    assign op = pick_op(clr, load_n, strobe_rise[0], strobe_rise[1]);

    count_core #(
        .WIDTH (WIDTH)
    ) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .preset (preset),
        .count  (count)
    );

    term_detect #(
        .WIDTH (WIDTH)
    ) u_term (
        .count    (count),
        .up_level (strobe_lvl[0]),
        .dn_level (strobe_lvl[1]),
        .carry_n  (carry_n),
        .borrow_n (borrow_n)
    );

endmodule

// File: rtl/dual_strobe_counter_chk.sv
module dual_strobe_counter_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             load_n,
    input logic [WIDTH-1:0] preset,
    input logic [WIDTH-1:0] count,
    input logic             carry_n,
    input logic             borrow_n
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] plus_q, minus_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            plus_q  <= ONE;
            minus_q <= TOP;
        end else begin
            plus_q  <= count + ONE;
            minus_q <= count - ONE;
        end
    end

    a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

    a_r8_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load_n) |=> (count == $past(preset)));

    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && load_n) |=> (count == $past(count) || count == plus_q || count == minus_q));

    a_r5_carry_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n |-> (count == TOP));

    a_r6_borrow_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !borrow_n |-> (count == '0));

endmodule

bind dual_strobe_counter dual_strobe_counter_chk #(
    .WIDTH (WIDTH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .load_n   (load_n),
    .preset   (preset),
    .count    (count),
    .carry_n  (carry_n),
    .borrow_n (borrow_n)
);

// File: tb/dual_strobe_counter_bench.sv
module dual_strobe_counter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 4;

    logic         clk = 1'b0;
    logic         rst_n, clr, load_n, inc, dec;
    logic [7:0]   preset8;
    logic [W-1:0] lo_count, hi_count;
    logic         lo_carry_n, lo_borrow_n, hi_carry_n, hi_borrow_n;

    int           checks = 0;
    int           errors = 0;
    logic [7:0]   model  = 8'h00;
    logic [7:0]   exp_q[$];
    string        tag_q[$];
    event         chk_ev;
    bit           done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_strobe_counter #(.WIDTH(W), .SYNC_STAGES(2)) u_dual_strobe_counter (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .preset(preset8[3:0]),
        .inc_strobe(inc), .dec_strobe(dec), .count(lo_count),
        .carry_n(lo_carry_n), .borrow_n(lo_borrow_n));

    dual_strobe_counter #(.WIDTH(W), .SYNC_STAGES(2)) u_hi (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .preset(preset8[7:4]),
        .inc_strobe(lo_carry_n), .dec_strobe(lo_borrow_n), .count(hi_count),
        .carry_n(hi_carry_n), .borrow_n(hi_borrow_n));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Scoreboard driver side: queue the expectation, let both stages settle
    task automatic score(input string tag);
        exp_q.push_back(model);
        tag_q.push_back(tag);
        wait_cyc(10);
        -> chk_ev;
        #1;
    endtask

    // Monitor side: pop and compare the chained 8-bit value
    initial begin
        forever begin
            @(chk_ev);
            check(tag_q.pop_front(), {24'h0, hi_count, lo_count}, {24'h0, exp_q.pop_front()});
        end
    end

    task automatic pulse_up(input string tag);
        inc = 1'b0; wait_cyc(4);
        inc = 1'b1; model = model + 8'd1;
        score(tag);
    endtask

    task automatic pulse_down(input string tag);
        dec = 1'b0; wait_cyc(4);
        dec = 1'b1; model = model - 8'd1;
        score(tag);
    endtask

    task automatic do_load(input logic [7:0] v);
        preset8 = v; load_n = 1'b0; wait_cyc(2);
        load_n = 1'b1; model = v; wait_cyc(8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; clr = 1'b0; load_n = 1'b1; inc = 1'b1; dec = 1'b1; preset8 = 8'h00;
        wait_cyc(3); rst_n = 1'b1; wait_cyc(2);
        check("R1 count", {28'h0, lo_count}, 32'h0);
        check("R1 carry_n", {31'h0, lo_carry_n}, 32'h1);
        check("R1 borrow_n", {31'h0, lo_borrow_n}, 32'h1);

        pulse_up("R2 up 1"); pulse_up("R2 up 2"); pulse_up("R2 up 3");

        // R12: latency of a strobe edge through synchronizer and register
        inc = 1'b0; wait_cyc(4); inc = 1'b1;
        wait_cyc(2); check("R12 no change after 2 edges", {28'h0, lo_count}, 32'h3);
        wait_cyc(1); check("R12 change at 3rd edge", {28'h0, lo_count}, 32'h4);
        model = 8'h04; score("R12 settled");

        pulse_down("R3 down 1"); pulse_down("R3 down 2");

        do_load(8'h0E); pulse_up("R11 to 0F"); pulse_up("R11 carry to 10");
        do_load(8'hFE); pulse_up("R4 to FF"); pulse_up("R4 wrap up to 00");
        pulse_down("R4 wrap down to FF");
        do_load(8'h10); pulse_down("R11 borrow to 0F");

        // R5 carry echo
        do_load(8'h0F);
        inc = 1'b0; wait_cyc(4);
        check("R5 carry_n low at top", {31'h0, lo_carry_n}, 32'h0);
        inc = 1'b1; wait_cyc(2);
        check("R5 carry_n high on rise", {31'h0, lo_carry_n}, 32'h1);
        model = 8'h10; score("R5 carry stepped upper");
        do_load(8'h03);
        inc = 1'b0; wait_cyc(4);
        check("R5 carry_n high below top", {31'h0, lo_carry_n}, 32'h1);
        inc = 1'b1; model = 8'h04; score("R5 plain step");

        // R6 borrow echo
        do_load(8'h20);
        dec = 1'b0; wait_cyc(4);
        check("R6 borrow_n low at zero", {31'h0, lo_borrow_n}, 32'h0);
        dec = 1'b1; model = 8'h1F; score("R6 borrow stepped upper");

        // R7 clear over load and strobes
        do_load(8'h55);
        preset8 = 8'hAA; clr = 1'b1; load_n = 1'b0; inc = 1'b0; wait_cyc(1);
        check("R7 clear beats load", {24'h0, hi_count, lo_count}, 32'h0);
        wait_cyc(2); inc = 1'b1; wait_cyc(4);
        clr = 1'b0; load_n = 1'b1; wait_cyc(8);
        model = 8'h00;
        check("R7 strobe ignored during clear", {24'h0, hi_count, lo_count}, 32'h0);

        // R8 load and ignored strobe
        preset8 = 8'h9C; load_n = 1'b0; wait_cyc(1);
        check("R8 load value", {24'h0, hi_count, lo_count}, 32'h9C);
        inc = 1'b0; wait_cyc(2); inc = 1'b1; wait_cyc(6);
        load_n = 1'b1; wait_cyc(8);
        model = 8'h9C;
        check("R8 strobe ignored during load", {24'h0, hi_count, lo_count}, 32'h9C);

        // R9 strobe held low across load, then across clear
        do_load(8'h20);
        inc = 1'b0; wait_cyc(3);
        preset8 = 8'h41; load_n = 1'b0; wait_cyc(3); load_n = 1'b1; wait_cyc(3);
        inc = 1'b1; model = 8'h42; score("R9 counted after load");
        dec = 1'b0; wait_cyc(3);
        clr = 1'b1; wait_cyc(3); clr = 1'b0; wait_cyc(3);
        dec = 1'b1; model = 8'hFF; score("R9 counted after clear");

        // R10 coincident edges
        do_load(8'h37);
        inc = 1'b0; dec = 1'b0; wait_cyc(4);
        inc = 1'b1; dec = 1'b1; score("R10 both edges hold");

        for (int i = 0; i < 20; i++) pulse_up("R11 chained up run");
        for (int i = 0; i < 24; i++) pulse_down("R11 chained down run");

        done = 1'b1;
        finish_run();
    end

endmodule